// File: doc/BRIEF.md
# Byte-Lane Static Memory with Single-Error Correction

This block models a word-wide static memory whose controls are active-low levels sampled on a clock: a chip select, a write strobe, a read (output) enable and two byte-lane enables. Each stored word carries a 5-bit Hamming check field, computed when the word is written. On every read the stored word is checked and any single flipped bit is repaired in the returned data. The repaired value goes only to the output and is never put back into the array. The data bus is split into an input word, an output word and a per-lane drive-enable pair, in place of a bidirectional pin.

Partial writes update one byte lane only. The lane that is not written comes from the corrected old word, so the new check field describes the merged word. A test port flips any one stored bit, so the repair can be exercised. Depth is set by the address-width parameter. Reads are registered, so the output appears one clock after the read is sampled. The controls are plain level strobes with no handshake, so there is no back-pressure. Every sampled cycle is acted on.

Top module: `ecc_sram_core`

## Requirements
- R1: In a cycle with `cs_n`=0, `we_n`=0 and both lane enables low, the whole `wdata` word is stored at `addr`, and a later read of that address returns it.
- R2: While `cs_n`=1, no write happens at all, including when `we_n`=0. In the cycle after such a sample, `rdata_oe` is 00 and `rdata` is 0.
- R3: `ub_n` governs bits 15..8 and `lb_n` governs bits 7..0. A write changes only the lanes whose enable is low. A write with both lane enables high changes nothing.
- R4: A read is sampled when `cs_n`=0, `oe_n`=0 and `we_n`=1. One clock later, `rdata_oe[1]` equals the inverse of `ub_n` and `rdata_oe[0]` equals the inverse of `lb_n`, and any lane whose drive-enable is 0 reads as zero.
- R5: When the sampled cycle has `oe_n`=1, or both lane enables high, the next cycle shows `rdata_oe`=00 and `rdata`=0.
- R6: `we_n`=0 takes priority over `oe_n`. A cycle with both low is a write, and the next cycle has `rdata_oe`=00.
- R7: The stored word is laid out as 21 bits. Bits 15..0 hold the data and bits 20..16 hold check bits 4..0. In the 21-bit Hamming codeword, data bit i occupies the i-th position (in ascending order) among positions 3..21 that are not powers of two, and check bit k is the XOR of the data bits whose position has bit k set. A flip of any single one of the 21 stored bits is corrected on read.
- R8: A corrected read does not write back. If check bits 0 and 1 of a clean word are flipped in turn, with a read between the two flips, the next read returns the data with bit 0 inverted.
- R9: A one-lane write takes the other lane from the corrected old word and recomputes the check field. After it, a single stored-bit flip is still corrected.
- R10: When `tst_flip`=1, the stored bit `tst_bit` of word `tst_addr` is inverted. Values 0..15 select data bits and 16..20 select check bits 0..4. A write to the same address in the same cycle wins, and the flip is dropped.
- R11: During reset, `rdata_oe` is 00 and `rdata` is 0. The array contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset of the output registers |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low read/output enable |
| ub_n | input | 1 | Active-low upper lane enable (bits 15..8) |
| lb_n | input | 1 | Active-low lower lane enable (bits 7..0) |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Corrected read data, zero in undriven lanes |
| rdata_oe | output | 2 | Per-lane drive enable {upper, lower} |
| tst_flip | input | 1 | Test: invert one stored bit this cycle |
| tst_addr | input | ADDR_W | Test: word to corrupt |
| tst_bit | input | 5 | Test: stored bit index 0..20 |

## Verification
The array is first filled with an address-derived arithmetic pattern and read back in full. This separates address decoding faults from data path faults. Correction is then tried with each of the 21 single-bit flips on several words, which tells a misplaced check position apart from a missing one. Partial writes onto a corrupted word, and the two-check-bit flip sequence, tell merge-from-corrected apart from merge-from-raw, and no-write-back apart from write-back. The control patterns (deselected, output disabled, no lanes, write with output enable low, one lane each) distinguish lane gating from strobe priority.

// File: rtl/ecc_sram_pkg.sv
`timescale 1ns/1ps
package ecc_sram_pkg;
  localparam int DATA_W = 16;
  localparam int CHK_W  = 5;
  localparam int CODE_W = DATA_W + CHK_W;

  // Codeword position of data bit idx: the idx-th non-power-of-two from 3 upward.
  function automatic int hc_pos(input int idx);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int p = 3; p < 32; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == idx && res == 0) res = p;
        cnt++;
      end
    end
    return res;
  endfunction

  function automatic logic [CHK_W-1:0] hc_check(input logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] c;
    c = '0;
    for (int i = 0; i < DATA_W; i++)
      for (int k = 0; k < CHK_W; k++)
        if (((hc_pos(i) >> k) & 1) == 1) c[k] = c[k] ^ d[i];
    return c;
  endfunction
endpackage

// File: rtl/hc_encoder.sv
`timescale 1ns/1ps
module hc_encoder
  import ecc_sram_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  check_o
);
  always_comb check_o = hc_check(data_i);
endmodule

// File: rtl/hc_decoder.sv
`timescale 1ns/1ps
module hc_decoder
  import ecc_sram_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  check_i,
  output logic [DATA_W-1:0] data_o
);
  logic [CHK_W-1:0] syn;

  always_comb begin
    syn    = hc_check(data_i) ^ check_i;
    data_o = data_i;
    for (int i = 0; i < DATA_W; i++)
      if (syn == CHK_W'(hc_pos(i))) data_o[i] = ~data_i[i];
  end
endmodule

// File: rtl/sram_store.sv
`timescale 1ns/1ps
module sram_store
  import ecc_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [CODE_W-1:0] wword_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [CODE_W-1:0] rword_o,
  input  logic              inj_en_i,
  input  logic [ADDR_W-1:0] inj_addr_i,
  input  logic [4:0]        inj_bit_i
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [CODE_W-1:0] mem [DEPTH];
  logic              live;

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wword_i;
    if (inj_en_i && !(we_i && inj_addr_i == waddr_i))
      mem[inj_addr_i] <= mem[inj_addr_i] ^ (CODE_W'(1) << inj_bit_i);
  end

  assign rword_o = mem[raddr_i];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;

  // R8: with no write and no flip, a stored word never changes (reads do not write back)
  a_r8_no_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(!we_i && !inj_en_i) && $stable(raddr_i)) |-> $stable(rword_o));
endmodule

// File: rtl/ecc_sram_core.sv
`timescale 1ns/1ps
module ecc_sram_core
  import ecc_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              ub_n,
  input  logic              lb_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  output logic [1:0]        rdata_oe,
  input  logic              tst_flip,
  input  logic [ADDR_W-1:0] tst_addr,
  input  logic [4:0]        tst_bit
);
  localparam int LANE_W = DATA_W / 2;

  logic [1:0]        lane_en;
  logic              wr_cyc, rd_cyc, do_write;
  logic [CODE_W-1:0] stored;
  logic [DATA_W-1:0] fixed, merged, lane_mask;
  logic [CHK_W-1:0]  new_chk;
  logic              live;

  assign lane_en  = {~ub_n, ~lb_n};
  assign wr_cyc   = !cs_n && !we_n;
  assign rd_cyc   = !cs_n && we_n && !oe_n && (lane_en != 2'b00);
  assign do_write = wr_cyc && (lane_en != 2'b00);

  sram_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we_i(do_write), .waddr_i(addr), .wword_i({new_chk, merged}),
    .raddr_i(addr), .rword_o(stored),
    .inj_en_i(tst_flip), .inj_addr_i(tst_addr), .inj_bit_i(tst_bit)
  );

  hc_decoder u_dec (
    .data_i(stored[DATA_W-1:0]), .check_i(stored[CODE_W-1:DATA_W]), .data_o(fixed)
  );

  generate
    for (genvar g = 0; g < 2; g++) begin : g_lane
      assign merged[g*LANE_W +: LANE_W]    = lane_en[g] ? wdata[g*LANE_W +: LANE_W]
                                                        : fixed[g*LANE_W +: LANE_W];
      assign lane_mask[g*LANE_W +: LANE_W] = {LANE_W{lane_en[g]}};
    end
  endgenerate

  hc_encoder u_enc (.data_i(merged), .check_o(new_chk));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      rdata_oe <= '0;
      live     <= 1'b0;
    end else begin
      live     <= 1'b1;
      rdata    <= rd_cyc ? (fixed & lane_mask) : '0;
      rdata_oe <= rd_cyc ? lane_en : 2'b00;
    end
  end

  // R2: a deselected sample leaves the outputs quiet
  a_r2_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(cs_n)) |-> (rdata_oe == 2'b00 && rdata == '0));
  // R4: lanes driven follow the sampled lane enables on a read
  a_r4_lanes_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(!cs_n && we_n && !oe_n)) |-> (rdata_oe == ~$past({ub_n, lb_n})));
  // R4: an undriven lane reads as zero
  a_r4_idle_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((rdata & ~{{LANE_W{rdata_oe[1]}}, {LANE_W{rdata_oe[0]}}}) == '0));
  // R6: a write sample never drives the outputs
  a_r6_write_silences: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(!cs_n && !we_n)) |-> (rdata_oe == 2'b00));
endmodule

// File: tb/sim_ecc_sram_core.sv
`timescale 1ns/1ps
module sim_ecc_sram_core;
  localparam int AW = 6;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, ub_n = 1'b1, lb_n = 1'b1;
  logic [AW-1:0] addr = '0, tst_addr = '0;
  logic [15:0]   wdata = '0;
  logic [15:0]   rdata;
  logic [1:0]    rdata_oe;
  logic          tst_flip = 1'b0;
  logic [4:0]    tst_bit = '0;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;
  logic [15:0] model [NW];

  always #5 clk = ~clk;

  ecc_sram_core #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .ub_n(ub_n), .lb_n(lb_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe),
    .tst_flip(tst_flip), .tst_addr(tst_addr), .tst_bit(tst_bit)
  );

  // Called at a falling edge; applies one sample, returns at the next falling edge.
  task automatic cyc(input logic c, input logic w, input logic o, input logic u,
                     input logic l, input logic [AW-1:0] a, input logic [15:0] d,
                     input logic f, input logic [AW-1:0] fa, input logic [4:0] fb);
    cs_n = c; we_n = w; oe_n = o; ub_n = u; lb_n = l; addr = a; wdata = d;
    tst_flip = f; tst_addr = fa; tst_bit = fb;
    @(posedge clk);
    @(negedge clk);
    cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; ub_n = 1'b1; lb_n = 1'b1; tst_flip = 1'b0;
  endtask

  task automatic chk(input string req, input logic [1:0] eo, input logic [15:0] ed);
    vectors++;
    if ({rdata_oe, rdata} !== {eo, ed}) begin
      fails++;
      $display("FAIL %s: got oe=%b data=%h, want oe=%b data=%h", req, rdata_oe, rdata, eo, ed);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic u, input logic l, input logic [15:0] d);
    cyc(1'b0, 1'b0, 1'b1, u, l, a, d, 1'b0, '0, '0);
    if (!u) model[a][15:8] = d[15:8];
    if (!l) model[a][7:0]  = d[7:0];
  endtask

  task automatic rd(input string req, input logic [AW-1:0] a, input logic u, input logic l,
                    input logic [15:0] exp);
    cyc(1'b0, 1'b1, 1'b0, u, l, a, 16'h0, 1'b0, '0, '0);
    chk(req, {~u, ~l}, exp & {{8{~u}}, {8{~l}}});
  endtask

  task automatic flip(input logic [AW-1:0] a, input logic [4:0] b);
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '0, 16'h0, 1'b1, a, b);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R11 reset", 2'b00, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: fill and sweep
    for (int a = 0; a < NW; a++) wr(AW'(a), 1'b0, 1'b0, 16'(a * 40503) ^ 16'h5A5A);
    for (int a = 0; a < NW; a++) rd("R1 full read", AW'(a), 1'b0, 1'b0, model[a]);

    // R7/R10: every single stored-bit flip on several words
    for (int s = 0; s < 8; s++) begin
      logic [AW-1:0] a;
      a = AW'(s * 9 + 1);
      for (int b = 0; b < 21; b++) begin
        flip(a, 5'(b));
        rd("R7 single flip corrected", a, 1'b0, 1'b0, model[a]);
        flip(a, 5'(b));
      end
    end

    // R4: lane reads
    rd("R4 upper lane only", 6'd3, 1'b0, 1'b1, model[3]);
    rd("R4 lower lane only", 6'd3, 1'b1, 1'b0, model[3]);

    // R3: lane writes and no-lane write
    wr(6'd4, 1'b0, 1'b1, 16'hA1B2);
    rd("R3 upper write", 6'd4, 1'b0, 1'b0, model[4]);
    wr(6'd4, 1'b1, 1'b0, 16'hC3D4);
    rd("R3 lower write", 6'd4, 1'b0, 1'b0, model[4]);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 6'd7, 16'hFFFF, 1'b0, '0, '0);
    rd("R3 no-lane write ignored", 6'd7, 1'b0, 1'b0, model[7]);

    // R2: deselected write and read
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 6'd8, 16'h1234, 1'b0, '0, '0);
    chk("R2 deselected write quiet", 2'b00, 16'h0000);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 6'd8, 16'h0, 1'b0, '0, '0);
    chk("R2 deselected read quiet", 2'b00, 16'h0000);
    rd("R2 deselected write ignored", 6'd8, 1'b0, 1'b0, model[8]);

    // R5: output enable high, no lanes
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 6'd8, 16'h0, 1'b0, '0, '0);
    chk("R5 oe high", 2'b00, 16'h0000);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 6'd8, 16'h0, 1'b0, '0, '0);
    chk("R5 no lanes", 2'b00, 16'h0000);

    // R6: write with output enable low
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd10, 16'h6E6E, 1'b0, '0, '0);
    model[10] = 16'h6E6E;
    chk("R6 write silences output", 2'b00, 16'h0000);
    rd("R6 write took effect", 6'd10, 1'b0, 1'b0, 16'h6E6E);

    // R8: no write-back (check bits 0 and 1 -> syndrome 3 -> data bit 0)
    flip(6'd11, 5'd16);
    rd("R8 first flip corrected", 6'd11, 1'b0, 1'b0, model[11]);
    flip(6'd11, 5'd17);
    rd("R8 no write-back", 6'd11, 1'b0, 1'b0, model[11] ^ 16'h0001);
    flip(6'd11, 5'd16);
    flip(6'd11, 5'd17);
    rd("R8 restored", 6'd11, 1'b0, 1'b0, model[11]);

    // R9: lane write over a corrupted word
    flip(6'd5, 5'd12);
    wr(6'd5, 1'b1, 1'b0, 16'h00C3);
    rd("R9 merge from corrected word", 6'd5, 1'b0, 1'b0, model[5]);
    flip(6'd5, 5'd3);
    rd("R9 code consistent after merge", 6'd5, 1'b0, 1'b0, model[5]);
    flip(6'd5, 5'd3);

    // R10: write wins over a flip to the same word
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 6'd9, 16'h3C5A, 1'b1, 6'd9, 5'd0);
    model[9] = 16'h3C5A;
    flip(6'd9, 5'd16);
    flip(6'd9, 5'd17);
    rd("R10 write beats flip", 6'd9, 1'b0, 1'b0, 16'h3C5A ^ 16'h0001);
    flip(6'd9, 5'd16);
    flip(6'd9, 5'd17);
    rd("R10 restored", 6'd9, 1'b0, 1'b0, 16'h3C5A);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got no completion, want completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule